// File: doc/BRIEF.md
# Late-Increment Prefix Adder with Absolute Difference

This block is a W-bit parallel prefix adder whose final carry row can add one more unit after the carry tree has settled. A single set of bit cells and a single carry tree serve three operations chosen by a two-bit mode: plain addition with an optional +1, end-around (modulo 2^W−1) addition, and the unsigned absolute difference of the two operands. Both the +1 and the conditional bit inversion happen in one row of cells placed after the tree. That row is driven by the tree's group "not-kill" terms, so the block needs no second adder and no result multiplexer.

In end-around mode the tree's own carry-out is fed back as the increment. In difference mode the second operand is inverted before the bit cells. The carry-out then picks one of two actions: apply the late increment, which gives A−B, or invert every sum bit, which gives B−A. The result and a one-bit flag are registered, so they appear one clock after the operands are sampled.

Top module: `late_inc_adder`

## Requirements
- R1: While rst_ni is low, sum_o and flag_o are 0.
- R2: sum_o and flag_o show the result for the inputs sampled at the previous rising clock edge. Between edges they do not follow input changes.
- R3: With mode_i = 2'b00 and inc_i = 0, sum_o = (A+B) mod 2^W and flag_o is the carry out of A+B.
- R4: With mode_i = 2'b00 and inc_i = 1, sum_o = (A+B+1) mod 2^W and flag_o is the carry out of A+B+1. For example, A = all ones and B = 0 give sum_o = 0 and flag_o = 1.
- R5: With mode_i = 2'b01, flag_o is the carry out of A+B. sum_o is A+B when that carry is 0, and A+B−2^W+1 when it is 1. inc_i has no effect.
- R6: With mode_i = 2'b01, an all-ones result is kept as is as the second form of zero. A+B = 2^W−1 gives all ones with flag_o = 0, and A = B = all ones gives all ones with flag_o = 1.
- R7: With mode_i = 2'b10, sum_o = |A−B| and inc_i has no effect.
- R8: With mode_i = 2'b10, flag_o = 1 exactly when A <= B. Equal operands give sum_o = 0 with flag_o = 1.
- R9: mode_i = 2'b11 behaves exactly like 2'b00, including its use of inc_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | W | Operand A |
| b_i | input | W | Operand B |
| inc_i | input | 1 | Late +1 request (modes 00 and 11 only) |
| mode_i | input | 2 | 00 add, 01 end-around add, 10 absolute difference, 11 same as 00 |
| sum_o | output | W | Registered result |
| flag_o | output | 1 | Carry out (modes 00, 01, 11) or A<=B indication (mode 10) |

## Verification
Two functions meet in the same cycle in end-around and difference modes: the tree's carry-out is formed, and that same carry-out becomes the late increment, or in difference mode the inversion choice. Operand pairs are chosen so that the sum lands just below, exactly on and just above 2^W, and the difference pairs include equal, adjacent and extreme values. A wrong feedback or a wrong inversion choice therefore shows up as an off-by-one or a complemented result. Each registered output is compared against a behavioural expectation computed with plain integer arithmetic from the inputs of the previous cycle.

// File: rtl/late_inc_pkg.sv
package late_inc_pkg;
  typedef enum logic [1:0] {
    MODE_ADD = 2'b00,
    MODE_MOD = 2'b01,
    MODE_ABS = 2'b10,
    MODE_RSV = 2'b11
  } mode_e;
endpackage

// File: rtl/late_inc_bit_cells.sv
module late_inc_bit_cells #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         invert_b_i,
  output logic [W-1:0] gen_o,
  output logic [W-1:0] nkill_o,
  output logic [W-1:0] prop_o
);
  logic [W-1:0] b_eff;

  assign b_eff   = invert_b_i ? ~b_i : b_i;
  assign gen_o   = a_i & b_eff;
  assign nkill_o = a_i | b_eff;
  assign prop_o  = a_i ^ b_eff;
endmodule

// File: rtl/late_inc_prefix_tree.sv
module late_inc_prefix_tree #(
  parameter int W = 16
) (
  input  logic [W-1:0] gen_i,
  input  logic [W-1:0] nkill_i,
  output logic [W-1:0] grp_g_o,
  output logic [W-1:0] grp_k_o
);
  localparam int LVL = (W > 1) ? $clog2(W) : 1;

  logic [LVL:0][W-1:0] g_lv;
  logic [LVL:0][W-1:0] k_lv;

  assign g_lv[0] = gen_i;
  assign k_lv[0] = nkill_i;

  // radix-2 tree with unit lateral fan-out per level
  for (genvar l = 0; l < LVL; l++) begin : g_lvl
    localparam int D = 1 << l;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= D) begin : g_cell
        assign g_lv[l+1][i] = g_lv[l][i] | (k_lv[l][i] & g_lv[l][i-D]);
        assign k_lv[l+1][i] = k_lv[l][i] & k_lv[l][i-D];
      end else begin : g_pass
        assign g_lv[l+1][i] = g_lv[l][i];
        assign k_lv[l+1][i] = k_lv[l][i];
      end
    end
  end

  assign grp_g_o = g_lv[LVL];
  assign grp_k_o = k_lv[LVL];
endmodule

// File: rtl/late_inc_late_row.sv
module late_inc_late_row #(
  parameter int W = 16
) (
  input  logic [W-1:0] prop_i,
  input  logic [W-1:0] grp_g_i,
  input  logic [W-1:0] grp_k_i,
  input  logic         inc_i,
  input  logic         invert_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  logic [W:0] late_c;

  // no group below bit 0: its late carry is the increment itself
  assign late_c[0] = inc_i;
  for (genvar i = 1; i <= W; i++) begin : g_lc
    assign late_c[i] = grp_g_i[i-1] | (inc_i & grp_k_i[i-1]);
  end

  assign sum_o   = (prop_i ^ late_c[W-1:0]) ^ {W{invert_i}};
  assign carry_o = late_c[W];
endmodule

// File: rtl/late_inc_adder.sv
module late_inc_adder
  import late_inc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         inc_i,
  input  logic [1:0]   mode_i,
  output logic [W-1:0] sum_o,
  output logic         flag_o
);
  mode_e        mode;
  logic         is_mod, is_abs;
  logic [W-1:0] gen, nkill, prop, grp_g, grp_k, sum_d;
  logic         cout, inc_eff, invert, late_carry, flag_d;

  assign mode   = mode_e'(mode_i);
  assign is_mod = (mode == MODE_MOD);
  assign is_abs = (mode == MODE_ABS);

  late_inc_bit_cells #(.W(W)) u_cells (
    .a_i        (a_i),
    .b_i        (b_i),
    .invert_b_i (is_abs),
    .gen_o      (gen),
    .nkill_o    (nkill),
    .prop_o     (prop)
  );

  late_inc_prefix_tree #(.W(W)) u_tree (
    .gen_i   (gen),
    .nkill_i (nkill),
    .grp_g_o (grp_g),
    .grp_k_o (grp_k)
  );

  assign cout    = grp_g[W-1];
  // end-around and difference both recycle the tree carry-out as the +1
  assign inc_eff = (is_mod || is_abs) ? cout : inc_i;
  assign invert  = is_abs & ~cout;

  late_inc_late_row #(.W(W)) u_row (
    .prop_i   (prop),
    .grp_g_i  (grp_g),
    .grp_k_i  (grp_k),
    .inc_i    (inc_eff),
    .invert_i (invert),
    .sum_o    (sum_d),
    .carry_o  (late_carry)
  );

  assign flag_d = is_abs ? ~cout : late_carry;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o  <= '0;
      flag_o <= 1'b0;
    end else begin
      sum_o  <= sum_d;
      flag_o <= flag_d;
    end
  end
endmodule

// File: rtl/late_inc_adder_chk.sv
module late_inc_adder_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         inc_i,
  input logic [1:0]   mode_i,
  input logic [W-1:0] sum_o,
  input logic         flag_o
);
  logic [W-1:0] a_q, b_q;
  logic         inc_q, vld_q;
  logic [1:0]   mode_q;
  logic [W:0]   raw, with_inc;
  logic [W-1:0] mod_res, abs_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0; b_q <= '0; inc_q <= 1'b0; mode_q <= 2'b00; vld_q <= 1'b0;
    end else begin
      a_q <= a_i; b_q <= b_i; inc_q <= inc_i; mode_q <= mode_i; vld_q <= 1'b1;
    end
  end

  assign raw      = {1'b0, a_q} + {1'b0, b_q};
  assign with_inc = raw + {{W{1'b0}}, inc_q};
  assign mod_res  = raw[W] ? (raw[W-1:0] + 1'b1) : raw[W-1:0];
  assign abs_res  = (a_q > b_q) ? (a_q - b_q) : (b_q - a_q);

  always @(negedge clk_i) begin
    if (!rst_ni) a_r1_reset_clear : assert (sum_o == '0 && !flag_o);
  end

  a_r3_add_result : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && mode_q == 2'b00) |-> ({flag_o, sum_o} == with_inc));

  a_r5_mod_result : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && mode_q == 2'b01) |-> (sum_o == mod_res && flag_o == raw[W]));

  a_r6_mod_ones_kept : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && mode_q == 2'b01 && raw[W-1:0] == {W{1'b1}}) |-> (sum_o == {W{1'b1}}));

  a_r7_abs_result : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && mode_q == 2'b10) |-> (sum_o == abs_res));

  a_r8_abs_flag : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && mode_q == 2'b10) |-> (flag_o == (a_q <= b_q)));

  a_r9_reserved_as_add : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && mode_q == 2'b11) |-> ({flag_o, sum_o} == with_inc));
endmodule

bind late_inc_adder late_inc_adder_chk #(.W(W)) u_chk (.*);

// File: tb/late_inc_adder_tb.sv
module late_inc_adder_tb;
  localparam int W = 16;
  localparam time CYC = 8ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         inc = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] sum;
  logic         flag;

  int n_chk = 0, n_err = 0;

  typedef struct {
    logic [W-1:0] s;
    logic         f;
    string        tag;
  } exp_t;
  exp_t exp_q[$];

  always #(CYC/2) clk = ~clk;

  late_inc_adder #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .inc_i(inc),
    .mode_i(mode), .sum_o(sum), .flag_o(flag)
  );

  function automatic exp_t model(logic [W-1:0] av, logic [W-1:0] bv, logic iv, logic [1:0] mv);
    exp_t   e;
    longint full = longint'(1) << W;
    longint ma = longint'(av), mb = longint'(bv), s, r;
    case (mv)
      2'b01: begin
        s = ma + mb;
        if (s >= full) begin r = s - full + 1; e.f = 1'b1; end
        else begin r = s; e.f = 1'b0; end
        e.tag = (r == full - 1) ? "R6" : "R5";
      end
      2'b10: begin
        if (ma > mb) begin r = ma - mb; e.f = 1'b0; end
        else begin r = mb - ma; e.f = 1'b1; end
        e.tag = (ma <= mb) ? "R8" : "R7";
      end
      default: begin
        s = ma + mb + (iv ? 1 : 0);
        r = s % full;
        e.f = (s >= full);
        e.tag = (mv == 2'b11) ? "R9" : (iv ? "R4" : "R3");
      end
    endcase
    e.s = r[W-1:0];
    return e;
  endfunction

  task automatic check(string tag, logic [W-1:0] s, logic f, logic [W-1:0] es, logic ef);
    n_chk++;
    if (s !== es || f !== ef) begin
      n_err++;
      $display("FAIL %s sum=%h flag=%b expected sum=%h flag=%b", tag, s, f, es, ef);
    end
  endtask

  task automatic step(logic [W-1:0] av, logic [W-1:0] bv, logic iv, logic [1:0] mv);
    exp_t e;
    @(negedge clk);
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      check(e.tag, sum, flag, e.s, e.f);
    end
    a = av; b = bv; inc = iv; mode = mv;
    exp_q.push_back(model(av, bv, iv, mv));
  endtask

  localparam logic [W-1:0] ONES = {W{1'b1}};

  initial begin
    exp_t e;
    a = 16'h1234; b = 16'h4321; inc = 1'b1; mode = 2'b00;
    repeat (3) @(negedge clk);
    check("R1", sum, flag, '0, 1'b0);
    rst_n = 1'b1;

    // add, both increment states
    step(16'h0001, 16'h0002, 1'b0, 2'b00);
    step(ONES, 16'h0000, 1'b1, 2'b00);
    step(ONES, ONES, 1'b0, 2'b00);
    step(ONES, ONES, 1'b1, 2'b00);
    step(16'h0000, 16'h0000, 1'b1, 2'b00);
    // end-around add, carry crossing points; inc must be ignored
    step(16'h8000, 16'h7FFF, 1'b1, 2'b01);
    step(ONES, ONES, 1'b0, 2'b01);
    step(16'h8000, 16'h8000, 1'b1, 2'b01);
    step(16'h8001, 16'h7FFF, 1'b0, 2'b01);
    step(16'h0000, 16'h0000, 1'b1, 2'b01);
    step(ONES, 16'h0001, 1'b1, 2'b01);
    // absolute difference
    step(16'h1234, 16'h1234, 1'b1, 2'b10);
    step(16'h0005, 16'h0003, 1'b1, 2'b10);
    step(16'h0003, 16'h0005, 1'b0, 2'b10);
    step(16'h0000, ONES, 1'b0, 2'b10);
    step(ONES, 16'h0000, 1'b1, 2'b10);
    step(16'h8000, 16'h7FFF, 1'b0, 2'b10);
    // reserved code
    step(ONES, 16'h0000, 1'b1, 2'b11);
    step(16'h4000, 16'hC000, 1'b0, 2'b11);

    // R2: output holds across an input change until the next edge
    step(16'h0010, 16'h0020, 1'b0, 2'b00);
    @(negedge clk);
    e = exp_q.pop_front();
    check(e.tag, sum, flag, e.s, e.f);
    a = 16'hAAAA; b = 16'h5555; inc = 1'b1; mode = 2'b10;
    #1;
    check("R2", sum, flag, 16'h0030, 1'b0);
    exp_q.push_back(model(a, b, inc, mode));

    for (int i = 0; i < 2000; i++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = (i % 7 == 0) ? ra : W'($urandom);
      if (i % 11 == 0) rb = ~ra;
      step(ra, rb, 1'($urandom), 2'(i % 4));
    end
    step('0, '0, 1'b0, 2'b00);
    @(negedge clk);
    e = exp_q.pop_front();
    check(e.tag, sum, flag, e.s, e.f);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CYC * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule